// File: doc/BRIEF.md
# Matrix Keypad Scanner with Shared General-Purpose Pins

This peripheral owns a set of sixteen pins and splits them, at run time, between a key matrix and plain general-purpose I/O. A map register marks which pins belong to the keypad. Column pins 0 to 7 serve as matrix columns, and row pins 8 to 14 serve as matrix rows. Every unmapped pin, and pin 15 always, acts as an ordinary GPIO pin. Each GPIO pin has a direction bit and an output data bit, and its level can be read back.

While the keypad owns pins, the block drives one mapped column low at a time. A prescaler register sets how long each column is driven, so the scan rate can be tuned to a fast or a very slow system clock. The block senses the rows, and a key reading must repeat unchanged for a parameterised number of whole scans before it is accepted. The block then places the accepted key code in a single-entry holding register and raises an interrupt. Reading the key register empties it.

The host reaches the registers through a simple synchronous bus: one write strobe, one read strobe and a three-bit address. Read data comes back one cycle after the read strobe.

Top module: `keyscan_gpio`

## Requirements
- R1: After reset, no pin is driven (pinOe is 0), keyIrq is low, and the direction, output, map and key registers read as zero.
- R2: For a pin not owned by the keypad, pinOe follows its direction bit (address 0, 1 = output) and pinOut follows its output-data bit (address 1), so 8 inputs plus 8 outputs can coexist.
- R3: A read of address 2 returns the pin levels; any register read returns its data on regRdata in the cycle after regRd.
- R4: Writes to the output-data register leave unchanged the bits of pins that the map register (address 3) gives to the keypad; those bits keep their old value in the register and in readback.
- R5: Mapped column pins are driven low one at a time, for PRESCALE+1 cycles each (address 4), in rising index order 0..7, wrapping around; an unmapped column slot drives nothing; mapped row pins are never driven.
- R6: A key reading is accepted only after DEB_SCANS consecutive identical scans; a press seen in fewer scans is never reported.
- R7: The key register (address 5) holds the code row*8+column in bits 5:0 and a valid flag in bit 8; keyIrq equals that flag.
- R8: If several keys are down in one scan, the one in the lowest column is reported, and within one column the lowest row.
- R9: A key that stays held is reported once; after a debounced release, pressing it again reports it again.
- R10: Reading the key register clears the valid flag and keyIrq; a key accepted while the flag is set is dropped, and the held code is kept.
- R11: A press is reported within (DEB_SCANS+1)*8*(PRESCALE+1)+4 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, valid the cycle after regRd |
| keyIrq | output | 1 | Key available interrupt |
| pinIn | input | 16 | Sensed pin levels |
| pinOut | output | 16 | Pin output levels |
| pinOe | output | 16 | Pin output enables |

## Verification
The checks assume that pinIn is already synchronous to clk and has settled by the sampling edge. The bench meets this by modelling the key matrix as a combinational pull-down, computed from pinOe and pinOut, and by changing key states only at falling edges. They also assume that regWr and regRd are never raised together and that regAddr holds a defined value whenever a strobe is high. Every bus task in the bench drives one strobe per cycle, at the falling edge.

// File: rtl/kpx_pkg.sv
package kpx_pkg;
  localparam int CODE_W = 6;

  typedef enum logic [2:0] {
    REG_DIR  = 3'd0,
    REG_OUT  = 3'd1,
    REG_IN   = 3'd2,
    REG_MAP  = 3'd3,
    REG_PRE  = 3'd4,
    REG_KEY  = 3'd5
  } regAddr_e;

  // strobes from scan control to datapath
  typedef struct packed {
    logic              push;
    logic [CODE_W-1:0] code;
  } scanEvt_t;
endpackage

// File: rtl/kpx_scan_ctrl.sv
module kpx_scan_ctrl
  import kpx_pkg::*;
#(
  parameter int NUM_COLS  = 8,
  parameter int NUM_ROWS  = 7,
  parameter int DEB_SCANS = 3,
  parameter int PRE_W     = 16,
  localparam int COL_W    = $clog2(NUM_COLS),
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int CNT_W    = $clog2(DEB_SCANS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PRE_W-1:0]    prescale,
  input  logic [NUM_COLS-1:0] colMap,
  input  logic [NUM_ROWS-1:0] rowMap,
  input  logic [NUM_ROWS-1:0] rowIn,
  output logic [COL_W-1:0]    colIdx,
  output scanEvt_t            evt
);
  logic [PRE_W-1:0]  preCnt;
  logic              tick;
  logic [NUM_ROWS-1:0] rowLow;
  logic [ROW_W-1:0]  firstRow;
  logic              sampleHit, hitNow, same, changed;
  logic [CODE_W-1:0] sampleCode, codeNow;
  logic              accHit, lastHit, debHit;
  logic [CODE_W-1:0] accCode, lastCode, debCode;
  logic [CNT_W-1:0]  stableCnt, cntNext;

  assign tick = (preCnt == prescale);

  always_comb begin
    rowLow   = ~rowIn & rowMap;
    firstRow = '0;
    for (int r = NUM_ROWS - 1; r >= 0; r--)
      if (rowLow[r]) firstRow = ROW_W'(r);
    sampleHit  = colMap[colIdx] && (|rowLow);
    sampleCode = (CODE_W'(firstRow) << 3) | CODE_W'(colIdx);
    hitNow     = accHit | sampleHit;
    codeNow    = accHit ? accCode : (sampleHit ? sampleCode : '0);
    same       = (hitNow == lastHit) && (codeNow == lastCode);
    if (!same)                                 cntNext = CNT_W'(1);
    else if (stableCnt == CNT_W'(DEB_SCANS))   cntNext = stableCnt;
    else                                       cntNext = stableCnt + CNT_W'(1);
    changed    = (hitNow != debHit) || (codeNow != debCode);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt <= '0; colIdx <= '0;
      accHit <= 1'b0; accCode <= '0;
      lastHit <= 1'b0; lastCode <= '0;
      debHit <= 1'b0; debCode <= '0;
      stableCnt <= '0;
      evt <= '0;
    end else begin
      evt.push <= 1'b0;
      preCnt   <= tick ? '0 : preCnt + PRE_W'(1);
      if (tick) begin
        if (colIdx == COL_W'(NUM_COLS - 1)) begin
          colIdx    <= '0;
          accHit    <= 1'b0;
          accCode   <= '0;
          lastHit   <= hitNow;
          lastCode  <= codeNow;
          stableCnt <= cntNext;
          if (cntNext >= CNT_W'(DEB_SCANS) && changed) begin
            debHit   <= hitNow;
            debCode  <= codeNow;
            evt.push <= hitNow;
            evt.code <= codeNow;
          end
        end else begin
          colIdx  <= colIdx + COL_W'(1);
          accHit  <= hitNow;
          accCode <= codeNow;
        end
      end
    end
  end
endmodule

// File: rtl/kpx_regs.sv
module kpx_regs
  import kpx_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int NUM_ROWS = 7,
  parameter int DATA_W   = 16,
  localparam int COL_W   = $clog2(NUM_COLS),
  localparam int KP_PINS = NUM_COLS + NUM_ROWS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  scanEvt_t          evt,
  input  logic [COL_W-1:0]  colIdx,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] regRdata,
  output logic              keyIrq,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe,
  output logic [DATA_W-1:0] prescale,
  output logic [DATA_W-1:0] mapReg
);
  localparam logic [DATA_W-1:0] MAP_MASK = DATA_W'((1 << KP_PINS) - 1);

  logic [DATA_W-1:0] dirReg, outReg;
  logic              keyValid;
  logic [CODE_W-1:0] keyCode;
  logic              keyRead;

  assign keyRead = regRd && (regAddr == REG_KEY);
  assign keyIrq  = keyValid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirReg <= '0; outReg <= '0; mapReg <= '0; prescale <= '0;
      keyValid <= 1'b0; keyCode <= '0; regRdata <= '0;
    end else begin
      if (regWr) begin
        case (regAddr)
          REG_DIR: dirReg   <= regWdata;
          REG_OUT: outReg   <= (regWdata & ~mapReg) | (outReg & mapReg);
          REG_MAP: mapReg   <= regWdata & MAP_MASK;
          REG_PRE: prescale <= regWdata;
          default: ;
        endcase
      end
      if (evt.push && (!keyValid || keyRead)) begin
        keyValid <= 1'b1;
        keyCode  <= evt.code;
      end else if (keyRead) begin
        keyValid <= 1'b0;
      end
      if (regRd) begin
        case (regAddr)
          REG_DIR: regRdata <= dirReg;
          REG_OUT: regRdata <= outReg;
          REG_IN:  regRdata <= pinIn;
          REG_MAP: regRdata <= mapReg;
          REG_PRE: regRdata <= prescale;
          REG_KEY: regRdata <= DATA_W'({keyValid, 2'b00, keyCode});
          default: regRdata <= '0;
        endcase
      end
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_pin
    if (i < NUM_COLS) begin : g_col
      assign pinOe[i]  = mapReg[i] ? (colIdx == COL_W'(i)) : dirReg[i];
      assign pinOut[i] = mapReg[i] ? 1'b0 : outReg[i];
    end else if (i < KP_PINS) begin : g_row
      assign pinOe[i]  = mapReg[i] ? 1'b0 : dirReg[i];
      assign pinOut[i] = mapReg[i] ? 1'b0 : outReg[i];
    end else begin : g_gpio
      assign pinOe[i]  = dirReg[i];
      assign pinOut[i] = outReg[i];
    end
  end
endmodule

// File: rtl/keyscan_gpio.sv
module keyscan_gpio
  import kpx_pkg::*;
#(
  parameter int NUM_COLS  = 8,
  parameter int NUM_ROWS  = 7,
  parameter int DATA_W    = 16,
  parameter int DEB_SCANS = 3,
  localparam int COL_W    = $clog2(NUM_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              keyIrq,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOe
);
  scanEvt_t          evt;
  logic [COL_W-1:0]  colIdx;
  logic [DATA_W-1:0] prescale, mapReg;

  kpx_scan_ctrl #(
    .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS),
    .DEB_SCANS(DEB_SCANS), .PRE_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .prescale(prescale),
    .colMap(mapReg[NUM_COLS-1:0]),
    .rowMap(mapReg[NUM_COLS +: NUM_ROWS]),
    .rowIn(pinIn[NUM_COLS +: NUM_ROWS]),
    .colIdx(colIdx), .evt(evt)
  );

  kpx_regs #(
    .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .evt(evt), .colIdx(colIdx),
    .pinIn(pinIn), .regRdata(regRdata), .keyIrq(keyIrq),
    .pinOut(pinOut), .pinOe(pinOe), .prescale(prescale), .mapReg(mapReg)
  );
endmodule

// File: rtl/keyscan_gpio_chk.sv
module keyscan_gpio_chk
  import kpx_pkg::*;
#(
  parameter int NUM_COLS = 8,
  parameter int NUM_ROWS = 7,
  parameter int DATA_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regRd,
  input logic [2:0]        regAddr,
  input logic              keyIrq,
  input logic [DATA_W-1:0] pinOe,
  input logic [DATA_W-1:0] mapReg,
  input scanEvt_t          evt
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!keyIrq && pinOe == '0));

  // R5
  one_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pinOe[NUM_COLS-1:0] & mapReg[NUM_COLS-1:0]));

  // R5
  row_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pinOe[NUM_COLS +: NUM_ROWS] & mapReg[NUM_COLS +: NUM_ROWS]) == '0);

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(keyIrq) |-> $past(evt.push));

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regRd && regAddr == REG_KEY && !evt.push) |=> !keyIrq);

  // R6
  push_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.push |=> !evt.push);
endmodule

bind keyscan_gpio keyscan_gpio_chk #(
  .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .regRd(regRd), .regAddr(regAddr),
  .keyIrq(keyIrq), .pinOe(pinOe), .mapReg(mapReg), .evt(evt)
);

// File: tb/keyscan_gpio_test.sv
`timescale 1ns/1ps
module keyscan_gpio_test;
  localparam int DEB     = 3;
  localparam int PRE     = 1;
  localparam int SCAN    = 8 * (PRE + 1);
  localparam int BOUND   = (DEB + 1) * SCAN + 4;
  localparam int EARLIEST = (DEB - 1) * SCAN - 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata, pinOut, pinOe, pinIn;
  logic        keyIrq;
  logic [15:0] gpioDrive = 16'hFFFF;
  logic [63:0] pressed = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  keyscan_gpio #(.DEB_SCANS(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .keyIrq(keyIrq), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  // key matrix: a pressed key pulls its row low while its column is driven low
  always_comb begin
    pinIn = gpioDrive;
    for (int r = 0; r < 7; r++)
      for (int c = 0; c < 8; c++)
        if (pressed[r*8+c] && pinOe[c] && !pinOut[c]) pinIn[8+r] = 1'b0;
  end

  // vectors: map=0; {dir, out, drive, expOe, expOut, expIn}
  localparam logic [15:0] VEC [5][6] = '{
    '{16'hFF00, 16'hA5C3, 16'h1234, 16'hFF00, 16'hA5C3, 16'h1234},
    '{16'h00FF, 16'h5A3C, 16'hFEDC, 16'h00FF, 16'h5A3C, 16'hFEDC},
    '{16'hFFFF, 16'h0001, 16'h0000, 16'hFFFF, 16'h0001, 16'h0000},
    '{16'h0000, 16'h8000, 16'hFFFF, 16'h0000, 16'h8000, 16'hFFFF},
    '{16'h0F0F, 16'hF00F, 16'h6699, 16'h0F0F, 16'hF00F, 16'h6699}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdata;
  endtask

  task automatic waitIrq(input int limit, output int n);
    n = 0;
    while (n < limit && !keyIrq) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pressCheck(input string tag, input logic [15:0] expKey);
    int n;
    logic [15:0] d;
    waitIrq(BOUND, n);
    check({tag, " R11 irq within bound"}, 32'(keyIrq), 32'd1);
    check({tag, " R6 not before debounce"}, 32'(n >= EARLIEST), 32'd1);
    regRead(3'd5, d);
    check({tag, " R7 key code"}, 32'(d), 32'(expKey));
    @(negedge clk);
    check({tag, " R10 irq cleared by read"}, 32'(keyIrq), 32'd0);
  endtask

  initial begin
    logic [15:0] d;
    int bad, trans, prevIdx, idx;

    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pinOe after reset", 32'(pinOe), 32'd0);
    check("R1 irq after reset", 32'(keyIrq), 32'd0);
    regRead(3'd0, d); check("R1 dir reg", 32'(d), 32'd0);
    regRead(3'd3, d); check("R1 map reg", 32'(d), 32'd0);
    regRead(3'd5, d); check("R1 key reg", 32'(d), 32'd0);

    // R2 R3 GPIO vectors
    foreach (VEC[v]) begin
      regWrite(3'd0, VEC[v][0]);
      regWrite(3'd1, VEC[v][1]);
      gpioDrive = VEC[v][2];
      @(negedge clk);
      check("R2 pinOe", 32'(pinOe), 32'(VEC[v][3]));
      check("R2 pinOut", 32'(pinOut), 32'(VEC[v][4]));
      regRead(3'd2, d);
      check("R3 pin read", 32'(d), 32'(VEC[v][5]));
    end
    gpioDrive = 16'hFFFF;

    // R4 keypad pins ignore output writes
    regWrite(3'd1, 16'h0000);
    regWrite(3'd0, 16'hFFFF);
    regWrite(3'd3, 16'h7FFF);
    regWrite(3'd1, 16'hFFFF);
    regRead(3'd1, d);
    check("R4 out reg keeps owned bits", 32'(d), 32'h8000);
    check("R5 owned rows undriven", 32'(pinOe[14:8]), 32'd0);
    regWrite(3'd3, 16'h0000);
    @(negedge clk);
    check("R4 pinOut after release", 32'(pinOut), 32'h8000);

    // R5 scan order and dwell
    regWrite(3'd0, 16'h0000);
    regWrite(3'd4, 16'(PRE));
    regWrite(3'd3, 16'h7FFF);
    bad = 0; trans = 0; prevIdx = -1;
    for (int k = 0; k < 4 * SCAN; k++) begin
      @(negedge clk);
      if ($countones(pinOe[7:0]) != 1 || pinOut[7:0] != 8'h00) bad++;
      idx = 0;
      for (int c = 0; c < 8; c++) if (pinOe[c]) idx = c;
      if (prevIdx >= 0 && idx != prevIdx) begin
        if (idx != (prevIdx + 1) % 8) bad++;
        trans++;
      end
      prevIdx = idx;
    end
    check("R5 one column low, rising order", 32'(bad), 32'd0);
    check("R5 dwell PRESCALE+1", 32'(trans >= 4 * 8 - 1 && trans <= 4 * 8), 32'd1);
    regWrite(3'd3, 16'h7F0F);
    bad = 0;
    for (int k = 0; k < 2 * SCAN; k++) begin
      @(negedge clk);
      if (pinOe[7:4] != 4'h0) bad++;
    end
    check("R5 unmapped columns idle", 32'(bad), 32'd0);
    regWrite(3'd3, 16'h7FFF);

    // R7 R11 single press row 2 col 5 -> 21
    pressed = '0; pressed[2*8+5] = 1'b1;
    pressCheck("single", 16'h0100 | 16'd21);
    // R9 held key not repeated
    cyc(6 * SCAN);
    check("R9 held key once", 32'(keyIrq), 32'd0);
    pressed = '0;
    cyc(6 * SCAN);
    check("R9 release not reported", 32'(keyIrq), 32'd0);
    pressed[2*8+5] = 1'b1;
    pressCheck("R9 repress", 16'h0100 | 16'd21);
    pressed = '0; cyc(6 * SCAN);

    // R8 priority across columns, then within a column
    pressed[3*8+6] = 1'b1; pressed[1*8+6] = 1'b1; pressed[4*8+2] = 1'b1;
    pressCheck("R8 lowest column", 16'h0100 | 16'd34);
    pressed = '0; cyc(6 * SCAN);
    pressed[5*8+3] = 1'b1; pressed[2*8+3] = 1'b1;
    pressCheck("R8 lowest row", 16'h0100 | 16'd19);
    pressed = '0; cyc(6 * SCAN);

    // R6 short press shorter than one scan
    pressed[0] = 1'b1;
    cyc(SCAN - 2);
    pressed = '0;
    cyc(6 * SCAN);
    check("R6 glitch ignored", 32'(keyIrq), 32'd0);

    // R10 second key dropped while first unread
    pressed[1*8+1] = 1'b1;
    begin
      int n;
      waitIrq(BOUND, n);
    end
    check("R10 first key irq", 32'(keyIrq), 32'd1);
    pressed = '0; cyc(6 * SCAN);
    pressed[6*8+7] = 1'b1; cyc(6 * SCAN);
    regRead(3'd5, d);
    check("R10 held code kept", 32'(d), 32'h0100 | 32'd9);
    cyc(6 * SCAN);
    check("R10 dropped key not raised", 32'(keyIrq), 32'd0);
    pressed = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule